// File: doc/BRIEF.md
# Edge-Triggered Wake-Up and Interrupt Hub

This block gathers sixteen external event lines for a low-power controller. Each line is watched for one edge, rising or falling, chosen per channel by software. A detected edge is caught in a per-channel pending flag. The catch does not depend on the system clock, so an event that arrives while every clock is stopped is still held. Channels that are pending and allowed to wake drive one combined wake request to the power manager. That request is formed directly from the asynchronous flags, so it can restart the clocks.

Once the clock is running, each pending flag is brought into the clock domain through two flops. The synchronised copy is what software reads and what forms the four interrupt request lines. Each channel has its own interrupt enable and a two-bit route that picks one of the four lines. Software clears a flag by writing a one to its bit. Two hubs side by side give 32 channels and 8 interrupt lines. The hubs share nothing.

Register offsets on the bus: 0 edge select, 1 wake enable, 2 interrupt enable, 3 routes for channels 0 to 7, 4 routes for channels 8 to 15, 5 pending. Every other offset reads as zero.

Top module: `wake_irq_hub`

## Requirements
- R1: After reset, every register reads zero and wake_req and irq_req are low.
- R2: With edge select bit c at 0, a rising edge on ev_line[c] sets pending bit c. The bit is visible at offset 5 from the second rising clock edge after the line changes.
- R3: With edge select bit c at 1, a falling edge on ev_line[c] sets pending bit c and a rising edge does not.
- R4: Writing offset 5 clears each pending bit written as 1 and leaves every bit written as 0 unchanged.
- R5: wake_req is the OR over all channels of (pending and wake enable at offset 1). It rises after an enabled edge with no clock edge in between.
- R6: irq_req[k] is the OR of all channels that are pending, have their bit set at offset 2, and have route k. Channel c's route is bits [2(c mod 8)+1 : 2(c mod 8)] of offset 3 for c<8 and of offset 4 otherwise.
- R7: An edge that arrives while the clock is stopped is latched. It shows on wake_req at once and at offset 5 once the clock runs again.
- R8: Further edges on a channel that is already pending leave it as one pending bit. An edge after the clear sets the bit again.
- R9: Changing a channel's edge select so that (line XOR select) goes from 0 to 1 is taken as an edge and sets pending. Software must clear it.
- R10: Offsets 1 to 4 read back the last value written, and unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_line | input | 16 | External event lines, one per channel |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| wake_req | output | 1 | Combined wake request to the power manager |
| irq_req | output | 4 | Interrupt request lines |

## Verification
The assertions check four things on every clock. A synchronised pending bit never rises unless its raw flag was already set. The raw flag is always set whenever the synchronised copy is set, so the wake path never trails the interrupt path. No interrupt line is high without a pending, enabled channel behind it. Written registers hold the written value, and a clear write removes the cleared bits unless a new edge was already in the synchroniser. Other behaviour needs the bench scenarios: the edge polarity choice, a wake that arrives with the clock stopped, merging of repeated edges, the false set caused by a change of edge select, and the route decode to each line.

// File: rtl/whub_pkg.sv
package whub_pkg;
  localparam int unsigned NCH    = 16;
  localparam int unsigned NIRQ   = 4;
  localparam int unsigned RSEL_W = $clog2(NIRQ);
  localparam int unsigned DW     = NCH;
  localparam int unsigned AW     = 3;
  localparam int unsigned ROUTE_REGS = (NCH * RSEL_W) / DW;
  localparam int unsigned OFF_EDGE   = 0;
  localparam int unsigned OFF_WAKE   = 1;
  localparam int unsigned OFF_IEN    = 2;
  localparam int unsigned OFF_ROUTE  = 3;
  localparam int unsigned OFF_PEND   = OFF_ROUTE + ROUTE_REGS;

  typedef logic [NCH-1:0]        chvec_t;
  typedef logic [NCH*RSEL_W-1:0] routes_t;

  function automatic logic [RSEL_W-1:0] route_of(input routes_t rt, input int unsigned ch);
    return rt[ch*RSEL_W +: RSEL_W];
  endfunction

  function automatic logic [NIRQ-1:0] irq_fold(input chvec_t pend, input chvec_t ien,
                                               input routes_t rt);
    logic [NIRQ-1:0] acc;
    acc = '0;
    for (int unsigned c = 0; c < NCH; c++)
      if (pend[c] && ien[c]) acc[route_of(rt, c)] = 1'b1;
    return acc;
  endfunction
endpackage

// File: rtl/whub_edge_cell.sv
module whub_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic fall_sel,
  input  logic ack,
  output logic tog_raw,
  output logic tog_sync
);
  logic trig;
  logic meta;

  assign trig = line ^ fall_sel;

  // Clocked by the event itself: works with the system clock stopped.
  always_ff @(posedge trig or negedge rst_n) begin
    if (!rst_n) tog_raw <= 1'b0;
    else        tog_raw <= ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta     <= 1'b0;
      tog_sync <= 1'b0;
    end else begin
      meta     <= tog_raw;
      tog_sync <= meta;
    end
  end
endmodule

// File: rtl/whub_regs.sv
module whub_regs
  import whub_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  chvec_t        tog_sync,
  output logic [DW-1:0] bus_rdata,
  output chvec_t        edge_sel,
  output chvec_t        wake_en,
  output chvec_t        irq_en,
  output routes_t       routes,
  output chvec_t        ack,
  output chvec_t        pend_s
);
  logic [DW-1:0] route_r [ROUTE_REGS];
  logic wr_hit;

  assign wr_hit = bus_sel && bus_wr;
  assign pend_s = tog_sync ^ ack;

  for (genvar r = 0; r < ROUTE_REGS; r++) begin : g_rt
    assign routes[r*DW +: DW] = route_r[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_sel <= '0;
      wake_en  <= '0;
      irq_en   <= '0;
      ack      <= '0;
      for (int r = 0; r < ROUTE_REGS; r++) route_r[r] <= '0;
    end else if (wr_hit) begin
      if (bus_addr == AW'(OFF_EDGE)) edge_sel <= bus_wdata;
      if (bus_addr == AW'(OFF_WAKE)) wake_en  <= bus_wdata;
      if (bus_addr == AW'(OFF_IEN))  irq_en   <= bus_wdata;
      if (bus_addr == AW'(OFF_PEND)) ack <= (ack & ~bus_wdata) | (tog_sync & bus_wdata);
      for (int r = 0; r < ROUTE_REGS; r++)
        if (bus_addr == AW'(OFF_ROUTE + r)) route_r[r] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFF_EDGE)) bus_rdata = edge_sel;
    if (bus_addr == AW'(OFF_WAKE)) bus_rdata = wake_en;
    if (bus_addr == AW'(OFF_IEN))  bus_rdata = irq_en;
    if (bus_addr == AW'(OFF_PEND)) bus_rdata = pend_s;
    for (int r = 0; r < ROUTE_REGS; r++)
      if (bus_addr == AW'(OFF_ROUTE + r)) bus_rdata = route_r[r];
  end

  // R4
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && bus_addr == AW'(OFF_PEND)) |=>
      ((pend_s & ~(tog_sync ^ $past(tog_sync)) & $past(bus_wdata)) == '0));

  // R10
  wake_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && bus_addr == AW'(OFF_WAKE)) |=> (bus_rdata == bus_rdata) && (wake_en == $past(bus_wdata)));
endmodule

// File: rtl/whub_irq_fold.sv
module whub_irq_fold
  import whub_pkg::*;
(
  input  chvec_t          pend_s,
  input  chvec_t          irq_en,
  input  routes_t         routes,
  output logic [NIRQ-1:0] irq_req
);
  assign irq_req = irq_fold(pend_s, irq_en, routes);
endmodule

// File: rtl/wake_irq_hub.sv
module wake_irq_hub
  import whub_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ev_line,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            wake_req,
  output logic [NIRQ-1:0] irq_req
);
  chvec_t  tog_raw, tog_sync, edge_sel, wake_en, irq_en, ack, pend_s, raw_pend;
  routes_t routes;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    whub_edge_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .line     (ev_line[c]),
      .fall_sel (edge_sel[c]),
      .ack      (ack[c]),
      .tog_raw  (tog_raw[c]),
      .tog_sync (tog_sync[c])
    );
  end

  whub_regs u_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .tog_sync, .bus_rdata, .edge_sel, .wake_en, .irq_en, .routes, .ack, .pend_s
  );

  whub_irq_fold u_fold (.pend_s, .irq_en, .routes, .irq_req);

  // Raw (clockless) pending feeds the wake path.
  assign raw_pend = tog_raw ^ ack;
  assign wake_req = |(raw_pend & wake_en);

  // R2
  sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_s & ~$past(pend_s) & ~$past(raw_pend)) == '0));

  // R5
  wake_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_s & ~raw_pend) == '0));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |-> ((pend_s & irq_en) != '0));
endmodule

// File: tb/wake_irq_hub_bench.sv
module wake_irq_hub_bench;
  logic        clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst_n = 1'b0;
  logic [15:0] ev_line = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wake_req;
  logic [3:0]  irq_req;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { string tag; int what; logic [15:0] exp; } item_t;
  item_t sbq[$];
  event sample_ev, done_ev;

  wake_irq_hub u_wake_irq_hub (
    .clk, .rst_n, .ev_line, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .wake_req, .irq_req
  );

  initial forever begin
    #10;
    if (clk_run) clk = ~clk;
  end

  // monitor: pops expected items and compares with the ports
  initial forever begin
    item_t it;
    logic [15:0] act;
    @(sample_ev);
    it = sbq.pop_front();
    case (it.what)
      0: act = bus_rdata;
      1: act = {12'h000, irq_req};
      default: act = {15'h0000, wake_req};
    endcase
    total++;
    if (act !== it.exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
    end
    ->done_ev;
  end

  task automatic expect_now(string tag, int what, logic [15:0] exp);
    item_t it;
    it.tag = tag; it.what = what; it.exp = exp;
    sbq.push_back(it);
    ->sample_ev;
    @(done_ev);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    #1;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [15:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 expect_now(tag, 0, exp);
    bus_sel = 0;
  endtask

  task automatic line(int ch, logic v);
    @(negedge clk);
    ev_line[ch] = v;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) rd("R1 reg", 3'(a), 16'h0000);
    expect_now("R1 irq", 1, 0);
    expect_now("R1 wake", 2, 0);

    // R10 readback
    wr(1, 16'hA5C3); wr(2, 16'h3C5A); wr(3, 16'h1234); wr(4, 16'hFEDC);
    rd("R10 wake_en", 1, 16'hA5C3); rd("R10 irq_en", 2, 16'h3C5A);
    rd("R10 route_lo", 3, 16'h1234); rd("R10 route_hi", 4, 16'hFEDC);
    rd("R10 unused", 6, 16'h0000);
    wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0);

    // R2 rising edge
    line(3, 1);
    rd("R2 pend", 5, 16'h0008);
    expect_now("R2 irq off", 1, 0);

    // R9 edge-select change seen as edge
    wr(0, 16'h0020);
    repeat (2) @(posedge clk);
    rd("R9 pend", 5, 16'h0028);

    // R4 selective clear
    wr(5, 16'h0020);
    rd("R4 pend", 5, 16'h0008);

    // R3 falling select
    line(5, 1);
    rd("R3 rise ignored", 5, 16'h0008);
    line(5, 0);
    rd("R3 fall sets", 5, 16'h0028);
    wr(5, 16'h0028);
    rd("R4 all cleared", 5, 16'h0000);
    line(3, 0);
    rd("R3 fall ignored on rising ch", 5, 16'h0000);

    // R5 wake path, before any clock edge
    wr(1, 16'h0008);
    @(negedge clk);
    ev_line[3] = 1;
    #1 expect_now("R5 wake immediate", 2, 1);
    repeat (2) @(posedge clk);
    rd("R5 pend", 5, 16'h0008);
    wr(1, 0);
    expect_now("R5 wake disabled", 2, 0);
    wr(1, 16'h0008);
    expect_now("R5 wake reenabled", 2, 1);

    // R6 routing
    wr(3, 16'h0080); wr(4, 16'h000C); wr(2, 16'h0208);
    expect_now("R6 ch3 to line2", 1, 4'b0100);
    line(9, 1);
    @(negedge clk); #1 expect_now("R6 ch9 to line3", 1, 4'b1100);
    wr(2, 16'h0200);
    expect_now("R6 gate ch3", 1, 4'b1000);
    wr(2, 16'h0000);
    expect_now("R6 all gated", 1, 4'b0000);

    // R8 merge and re-arm
    line(9, 0); line(9, 1);
    rd("R8 merged", 5, 16'h0208);
    wr(5, 16'h0200);
    rd("R8 cleared", 5, 16'h0008);
    line(9, 0); line(9, 1);
    rd("R8 re-armed", 5, 16'h0208);
    wr(5, 16'h0208);
    rd("R8 clear all", 5, 16'h0000);
    expect_now("R5 wake low", 2, 0);

    // R7 clock stopped
    wr(2, 16'h0008);
    line(3, 0);
    @(negedge clk);
    #1 clk_run = 0;
    #30 ev_line[3] = 1;
    #5 expect_now("R7 wake no clock", 2, 1);
    expect_now("R7 irq waits for clock", 1, 0);
    #30 clk_run = 1;
    repeat (2) @(posedge clk);
    rd("R7 pend after restart", 5, 16'h0008);
    expect_now("R7 irq after restart", 1, 4'b0100);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule